// File: doc/BRIEF.md
# Accumulator Datapath with Horizontal Control Word

This block is a one-register processing element steered by a wide control word and not by encoded opcodes. A program counter selects a word from an on-block instruction memory every clock. Separate bit fields of that word pick the operand (an 8-bit constant in the word, the external input port, or a word of the on-block data RAM), choose what happens to the accumulator (load, add, subtract), and request a store of the accumulator into the data RAM. Every word finishes in one clock, and no field can alter the order in which words are fetched.

The instruction memory is filled through a write port while the block is held in reset. When reset is released the block runs the program from word 0, and the accumulator is visible at all times on the output port. The data RAM is not cleared, so a program stores to a word before it reads it.

Top module: `acc_core`

## Requirements
- R1: A synchronous reset forces the accumulator, and so the output port, to zero and sets the program counter to zero, so the first clock after reset executes word 0.
- R2: The program counter steps by one on every clock outside reset, whatever the word holds, and wraps from the last word (255) back to word 0.
- R3: Source field bits [3:2] = 00 selects the constant in bits [20:13] as the operand.
- R4: Source field bits [3:2] = 01 selects the external input port as the operand.
- R5: Source field bits [3:2] = 10 or 11 selects the data RAM word addressed by bits [12:5], read in the same clock.
- R6: Operation field bits [1:0] = 10 or 11 loads the operand into the accumulator.
- R7: Operation field bits [1:0] = 01 replaces the accumulator with accumulator minus operand, modulo 256.
- R8: Operation field bits [1:0] = 00 replaces the accumulator with accumulator plus operand, modulo 256.
- R9: With bit 4 = 1 the accumulator value held before the clock edge is written to the data RAM word addressed by bits [12:5], even when the same word changes the accumulator.
- R10: With bit 4 = 0 no data RAM word changes.
- R11: The output port always shows the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| prog_we | input | 1 | Write strobe for the instruction memory |
| prog_addr | input | 8 | Instruction memory word to write |
| prog_word | input | 21 | Control word to write |
| inp | input | 8 | External operand input |
| outp | output | 8 | Accumulator value |

## Verification
The bench uses the default parameters: an 8-bit datapath, an 8-bit RAM address and an 8-bit program counter, so each control word is 21 bits and the instruction memory has 256 words. At that size a 300-clock run passes the counter wrap and executes word 0 a second time, and the data RAM's top address 255 is reachable from the address field. Operand values are chosen so that both sums and differences cross the modulo-256 boundary, and one store shares its clock with an accumulator update to expose the value that is written.

// File: rtl/acc_pkg.sv
package acc_pkg;

  // operand source field
  typedef enum logic [1:0] {
    SRC_CONST = 2'b00,
    SRC_PORT  = 2'b01,
    SRC_MEM_A = 2'b10,
    SRC_MEM_B = 2'b11
  } src_e;

  // accumulator action field
  typedef enum logic [1:0] {
    ACT_ADD  = 2'b00,
    ACT_SUB  = 2'b01,
    ACT_LD_A = 2'b10,
    ACT_LD_B = 2'b11
  } act_e;

  // width of the low control bits: action(2) + source(2) + store(1)
  localparam int CTL_W = 5;

endpackage

// File: rtl/acc_imem.sv
module acc_imem #(
  parameter int PC_W = 8,
  parameter int IW   = 21
) (
  input  logic            clk,
  input  logic            we,
  input  logic [PC_W-1:0] waddr,
  input  logic [IW-1:0]   wdata,
  input  logic [PC_W-1:0] raddr,
  output logic [IW-1:0]   rdata
);
  localparam int DEPTH = 1 << PC_W;

  logic [IW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/acc_dram.sv
module acc_dram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  // read path is combinational so a memory operand finishes in one clock
  assign rdata = cells[addr];

  // R9
  store_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> cells[$past(addr)] == $past(wdata));

  // R10
  no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> cells[$past(addr)] == $past(rdata));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  act_e              act,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] res
);
  // next accumulator value; arithmetic wraps at the word width
  function automatic logic [DATA_W-1:0] next_acc(
    input act_e              a,
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] val
  );
    unique case (a)
      ACT_ADD: return DATA_W'(cur + val);
      ACT_SUB: return DATA_W'(cur - val);
      default: return val;
    endcase
  endfunction

  assign res = next_acc(act, acc, opnd);
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int PC_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        prog_we,
  input  logic [PC_W-1:0]             prog_addr,
  input  logic [DATA_W+ADDR_W+CTL_W-1:0] prog_word,
  input  logic [DATA_W-1:0]           inp,
  output logic [DATA_W-1:0]           outp
);
  // control word layout, low to high: action, source, store, address, constant
  localparam int ACT_LSB = 0;
  localparam int SRC_LSB = 2;
  localparam int ST_BIT  = 4;
  localparam int ADR_LSB = CTL_W;
  localparam int K_LSB   = ADR_LSB + ADDR_W;
  localparam int IW      = K_LSB + DATA_W;

  logic [PC_W-1:0]   pc_q;
  logic [DATA_W-1:0] acc_q;
  logic [IW-1:0]     word;

  // decoded fields, each wired straight from the word
  act_e              act_f;
  src_e              src_f;
  logic              st_f;
  logic [ADDR_W-1:0] adr_f;
  logic [DATA_W-1:0] k_f;

  assign act_f = act_e'(word[ACT_LSB +: 2]);
  assign src_f = src_e'(word[SRC_LSB +: 2]);
  assign st_f  = word[ST_BIT];
  assign adr_f = word[ADR_LSB +: ADDR_W];
  assign k_f   = word[K_LSB +: DATA_W];

  // named events for the checks
  logic store_evt, add_evt, sub_evt, load_evt;
  assign store_evt = st_f & ~rst;
  assign add_evt   = (act_f == ACT_ADD) & ~rst;
  assign sub_evt   = (act_f == ACT_SUB) & ~rst;
  assign load_evt  = act_f[1] & ~rst;

  logic [DATA_W-1:0] mem_rd;
  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] acc_nxt;

  acc_imem #(.PC_W(PC_W), .IW(IW)) u_imem (
    .clk   (clk),
    .we    (prog_we),
    .waddr (prog_addr),
    .wdata (prog_word),
    .raddr (pc_q),
    .rdata (word)
  );

  // the store takes the accumulator from before the edge
  acc_dram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dram (
    .clk   (clk),
    .rst   (rst),
    .we    (store_evt),
    .addr  (adr_f),
    .wdata (acc_q),
    .rdata (mem_rd)
  );

  always_comb begin
    unique case (src_f)
      SRC_CONST: opnd = k_f;
      SRC_PORT:  opnd = inp;
      default:   opnd = mem_rd;
    endcase
  end

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .act  (act_f),
    .acc  (acc_q),
    .opnd (opnd),
    .res  (acc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      acc_q <= '0;
    end else begin
      pc_q  <= PC_W'(pc_q + 1'b1);
      acc_q <= acc_nxt;
    end
  end

  assign outp = acc_q;

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (pc_q == '0) && (acc_q == '0));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(pc_q) |=> pc_q == PC_W'($past(pc_q) + 1'b1));

  // R8
  add_chk: assert property (@(posedge clk) disable iff (rst)
    add_evt |=> DATA_W'(acc_q - $past(opnd)) == $past(acc_q));

  // R7
  sub_chk: assert property (@(posedge clk) disable iff (rst)
    sub_evt |=> DATA_W'(acc_q + $past(opnd)) == $past(acc_q));

  // R6
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> acc_q == $past(opnd));

  // R11
  outp_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> outp == DATA_W'($past(outp) - $past(acc_q) + $past(acc_nxt)));
endmodule

// File: tb/acc_core_test.sv
`timescale 1ns/1ps
module acc_core_test;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int PW = 8;
  localparam int IW = DW + AW + 5;
  localparam int NW = 1 << PW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          prog_we = 1'b0;
  logic [PW-1:0] prog_addr = '0;
  logic [IW-1:0] prog_word = '0;
  logic [DW-1:0] inp = '0;
  logic [DW-1:0] outp;

  always #10 clk = ~clk;  // 50 MHz

  acc_core uut (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_word(prog_word), .inp(inp), .outp(outp)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t sbq[$];

  logic [IW-1:0] prog [NW];
  logic [7:0]    pin  [NW];
  string         ptag [NW];

  // reference state
  logic [7:0] m_acc;
  logic [7:0] m_ram [256];

  function automatic logic [IW-1:0] mk(input logic [7:0] k, input logic [7:0] a,
                                       input logic st, input logic [1:0] src,
                                       input logic [1:0] act);
    return {k, a, st, src, act};
  endfunction

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: outp=%02h expected=%02h", tag, got, exp);
    end
  endtask

  // monitor: samples 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      check(outp, e.val, e.tag);
    end
  end

  task automatic clear_prog();
    for (int i = 0; i < NW; i++) begin
      prog[i] = '0;
      pin[i]  = '0;
      ptag[i] = "R8";
    end
  endtask

  task automatic load_prog();
    rst = 1'b1;
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      prog_we   = 1'b1;
      prog_addr = PW'(i);
      prog_word = prog[i];
    end
    @(negedge clk);
    prog_we = 1'b0;
    @(negedge clk);
    check(outp, 8'h00, "R1");
  endtask

  // driver: releases reset, steps the reference, pushes expectations
  task automatic run_prog(input int n);
    m_acc = 8'h00;
    for (int s = 0; s < n; s++) begin
      logic [IW-1:0] w;
      logic [7:0] k, a, opv, nxt;
      logic st;
      logic [1:0] src, act;
      exp_t e;
      @(negedge clk);
      rst = 1'b0;
      w   = prog[s % NW];
      inp = pin[s % NW];
      {k, a, st, src, act} = w;
      if (src == 2'b00)      opv = k;
      else if (src == 2'b01) opv = inp;
      else                   opv = m_ram[a];
      if (act[1])            nxt = opv;
      else if (act == 2'b01) nxt = m_acc - opv;
      else                   nxt = m_acc + opv;
      if (st) m_ram[a] = m_acc;
      m_acc = nxt;
      e.val = nxt;
      e.tag = ptag[s % NW];
      sbq.push_back(e);
    end
    while (sbq.size() > 0) @(negedge clk);
    rst = 1'b1;
  endtask

  initial begin
    // program 1: constants, port operand, load/add/subtract with wrap
    clear_prog();
    prog[0] = mk(8'h12, 8'h00, 1'b0, 2'b00, 2'b10); ptag[0] = "R1";
    prog[1] = mk(8'h05, 8'h00, 1'b0, 2'b00, 2'b00); ptag[1] = "R3";
    prog[2] = mk(8'h20, 8'h00, 1'b0, 2'b00, 2'b01); ptag[2] = "R7";
    prog[3] = mk(8'h10, 8'h00, 1'b0, 2'b00, 2'b00); ptag[3] = "R8";
    prog[4] = mk(8'h00, 8'h00, 1'b0, 2'b01, 2'b11); ptag[4] = "R4"; pin[4] = 8'h5A;
    prog[5] = mk(8'h00, 8'h00, 1'b0, 2'b01, 2'b00); ptag[5] = "R11"; pin[5] = 8'hA6;
    prog[6] = mk(8'h00, 8'h00, 1'b0, 2'b01, 2'b01); ptag[6] = "R7"; pin[6] = 8'h01;
    prog[7] = mk(8'h33, 8'h00, 1'b0, 2'b00, 2'b11); ptag[7] = "R6";
    load_prog();
    run_prog(8);

    // program 2: data RAM stores, suppressed store, RAM operands
    clear_prog();
    prog[0] = mk(8'h41, 8'h00, 1'b0, 2'b00, 2'b10); ptag[0] = "R6";
    prog[1] = mk(8'h01, 8'h10, 1'b1, 2'b00, 2'b00); ptag[1] = "R9";
    prog[2] = mk(8'h99, 8'hFF, 1'b1, 2'b00, 2'b10); ptag[2] = "R9";
    prog[3] = mk(8'h77, 8'h10, 1'b0, 2'b00, 2'b10); ptag[3] = "R10";
    prog[4] = mk(8'h00, 8'h10, 1'b0, 2'b10, 2'b10); ptag[4] = "R10";
    prog[5] = mk(8'h00, 8'hFF, 1'b0, 2'b11, 2'b00); ptag[5] = "R5";
    prog[6] = mk(8'h00, 8'h10, 1'b0, 2'b10, 2'b01); ptag[6] = "R5";
    prog[7] = mk(8'h00, 8'h20, 1'b1, 2'b00, 2'b00); ptag[7] = "R9";
    prog[8] = mk(8'h00, 8'h20, 1'b0, 2'b00, 2'b10); ptag[8] = "R10";
    prog[9] = mk(8'h00, 8'h20, 1'b0, 2'b11, 2'b11); ptag[9] = "R9";
    load_prog();
    run_prog(10);

    // program 3: counter wrap, word 0 runs again after word 255
    clear_prog();
    prog[0] = mk(8'hA0, 8'h00, 1'b0, 2'b00, 2'b10); ptag[0] = "R2";
    for (int i = 1; i < NW; i++) begin
      prog[i] = mk(8'h01, 8'h00, 1'b0, 2'b00, 2'b00);
      ptag[i] = "R2";
    end
    load_prog();
    run_prog(300);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule